// File: doc/BRIEF.md
# Burst Byte-Enable Legality Checker

This block watches a memory-mapped write stream and checks each beat's byte-enable mask. The check depends on where the beat sits within its burst. A beat that starts a multi-beat burst may leave out only its low bytes. A beat that ends a multi-beat burst may leave out only its high bytes. Every beat in between must enable all lanes. A transfer that is a burst of its own must enable one naturally aligned group of lanes whose size is a power of two.

A beat is taken into account only in a cycle where both valid and ready are high. The burst length is read from the length field on the beat that opens a burst, and the block then counts down the beats that remain. An illegal beat produces a pulse one cycle long, sets a sticky flag, and records the zero-based index of the first offending beat within its burst. The block has no effect on the stream; it only observes it.

Top module: `be_burst_checker`

## Requirements
- R1: On the opening beat of a burst whose length is 2 or more, the mask is legal only when it is 4'b1111, 4'b1110, 4'b1100 or 4'b1000. Bit i of the mask enables byte lane i.
- R2: On the closing beat of a burst whose length is 2 or more, the mask is legal only when it is 4'b1111, 4'b0111, 4'b0011 or 4'b0001.
- R3: Every beat strictly between the opening and closing beats is legal only with mask 4'b1111.
- R4: A beat that opens a burst with length 1 or 0 is checked as a lone transfer. Its legal masks are 4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100 and 4'b1000.
- R5: The position within a burst advances only on an accepted beat (valid and ready both high). A stalled cycle leaves it unchanged.
- R6: The length field is sampled only on the opening beat. Its value on later beats of the same burst has no effect.
- R7: `err_pulse` is high for exactly the one cycle after an accepted illegal beat, and is low after an accepted legal beat.
- R8: `err_sticky` rises together with the first `err_pulse` and stays high until reset.
- R9: `err_beat` holds the zero-based index within its burst of the first illegal beat. Later illegal beats leave it unchanged.
- R10: A synchronous reset (`rst_n` low at a clock edge) clears `err_pulse`, `err_sticky` and `err_beat` to zero and ends any burst in progress.
- R11: A cycle with valid high and ready low is not checked and produces no error pulse, whatever its mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Write beat valid |
| in_ready | input | 1 | Write beat accepted by the slave |
| in_burst | input | CNT_W | Burst length in beats, read on the opening beat |
| in_be | input | BE_W | Byte-enable mask of the beat |
| err_pulse | output | 1 | One-cycle flag for an illegal accepted beat |
| err_sticky | output | 1 | Set by the first illegal beat, cleared only by reset |
| err_beat | output | CNT_W | Index within its burst of the first illegal beat |

## Verification
The bench builds the block with its default values, BE_W = 4 and CNT_W = 8. With four lanes, all sixteen mask values can be applied in each of the four beat positions, so every legal and illegal code in R1 to R4 is covered, including the empty mask and masks with gaps. An 8-bit length field allows bursts of 0, 1, 2, 3 and 4 beats. With these lengths the bench covers lone transfers, bursts that have no middle beat, stalls in the middle of a burst, and error-index capture at a position other than zero.

// File: rtl/be_chk_pkg.sv
package be_chk_pkg;

    typedef enum logic [1:0] {
        POS_SINGLE = 2'd0,
        POS_FIRST  = 2'd1,
        POS_MID    = 2'd2,
        POS_LAST   = 2'd3
    } beat_pos_e;

endpackage

// File: rtl/beat_tracker.sv
module beat_tracker
    import be_chk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [CNT_W-1:0] burst_len,
    output beat_pos_e        pos,
    output logic [CNT_W-1:0] beat_idx
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] remain;
        logic [CNT_W-1:0] idx;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (!trk_q.active) begin
            pos = (burst_len <= ONE) ? POS_SINGLE : POS_FIRST;
        end else if (trk_q.remain == ONE) begin
            pos = POS_LAST;
        end else begin
            pos = POS_MID;
        end
        beat_idx = trk_q.active ? trk_q.idx : '0;

        if (acc) begin
            unique case (pos)
                POS_SINGLE: begin
                    trk_d = '0;
                end
                POS_FIRST: begin
                    trk_d.active = 1'b1;
                    trk_d.remain = burst_len - ONE;
                    trk_d.idx    = ONE;
                end
                POS_MID: begin
                    trk_d.remain = trk_q.remain - ONE;
                    trk_d.idx    = trk_q.idx + ONE;
                end
                POS_LAST: begin
                    trk_d = '0;
                end
                default: trk_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/be_classifier.sv
module be_classifier
    import be_chk_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  beat_pos_e       pos,
    input  logic [BE_W-1:0] be,
    output logic            illegal
);

    localparam logic [BE_W-1:0] ALL = '1;

    logic [BE_W-1:0] be_dec;
    logic [BE_W-1:0] be_inc;
    logic            ok_first;
    logic            ok_last;
    logic            ok_mid;
    logic            ok_single;

    always_comb begin
        be_dec   = be - 1'b1;
        be_inc   = be + 1'b1;
        // ones reach the top lane with no gap below the lowest set lane
        ok_first = (be != '0) && ((be | be_dec) == ALL);
        // ones start at lane 0 with no gap above
        ok_last  = (be != '0) && ((be & be_inc) == '0);
        ok_mid   = (be == ALL);

        // lone transfer: a power-of-two group of lanes aligned to its size
        ok_single = 1'b0;
        for (int sz = 1; sz <= BE_W; sz = sz * 2) begin
            for (int off = 0; off < BE_W; off = off + sz) begin
                if (be == (BE_W'((1 << sz) - 1) << off)) begin
                    ok_single = 1'b1;
                end
            end
        end

        unique case (pos)
            POS_SINGLE: illegal = !ok_single;
            POS_FIRST:  illegal = !ok_first;
            POS_MID:    illegal = !ok_mid;
            POS_LAST:   illegal = !ok_last;
            default:    illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/err_capture.sv
module err_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             illegal,
    input  logic [CNT_W-1:0] beat_idx,
    output logic             err_pulse,
    output logic             err_sticky,
    output logic [CNT_W-1:0] err_beat
);

    typedef struct packed {
        logic             pulse;
        logic             sticky;
        logic [CNT_W-1:0] beat;
    } cap_t;

    cap_t cap_d, cap_q;
    logic hit;

    always_comb begin
        hit         = acc && illegal;
        cap_d       = cap_q;
        cap_d.pulse = hit;
        if (hit && !cap_q.sticky) begin
            cap_d.sticky = 1'b1;
            cap_d.beat   = beat_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign err_pulse  = cap_q.pulse;
    assign err_sticky = cap_q.sticky;
    assign err_beat   = cap_q.beat;

endmodule

// File: rtl/be_burst_checker.sv
module be_burst_checker
    import be_chk_pkg::*;
#(
    parameter int BE_W  = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ready,
    input  logic [CNT_W-1:0] in_burst,
    input  logic [BE_W-1:0]  in_be,
    output logic             err_pulse,
    output logic             err_sticky,
    output logic [CNT_W-1:0] err_beat
);

    logic             acc;
    beat_pos_e        pos;
    logic [CNT_W-1:0] beat_idx;
    logic             illegal;

    assign acc = in_valid && in_ready;

    beat_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .burst_len (in_burst),
        .pos       (pos),
        .beat_idx  (beat_idx)
    );

    be_classifier #(.BE_W(BE_W)) u_cls (
        .pos     (pos),
        .be      (in_be),
        .illegal (illegal)
    );

    err_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .illegal    (illegal),
        .beat_idx   (beat_idx),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky),
        .err_beat   (err_beat)
    );

endmodule

// File: rtl/be_burst_checker_sva.sv
module be_burst_checker_sva
    import be_chk_pkg::*;
#(
    parameter int BE_W  = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [BE_W-1:0]  in_be,
    input beat_pos_e        pos,
    input logic             err_pulse,
    input logic             err_sticky,
    input logic [CNT_W-1:0] err_beat
);

    AST_PULSE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(in_valid && in_ready)); // R7

    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> !err_pulse); // R11

    AST_MID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && pos == POS_MID && in_be != '1) |=> err_pulse); // R3

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R8

    AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky); // R8

    AST_BEAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_sticky) |-> $stable(err_beat)); // R9

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_ready) && (pos == POS_MID || pos == POS_LAST)) |=> $stable(pos)); // R5

endmodule

bind be_burst_checker be_burst_checker_sva #(.BE_W(BE_W), .CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_be      (in_be),
    .pos        (pos),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky),
    .err_beat   (err_beat)
);

// File: tb/tb_be_burst_checker.sv
module tb_be_burst_checker;

    localparam int BE_W  = 4;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready = 1'b0;
    logic [CNT_W-1:0] in_burst = '0;
    logic [BE_W-1:0]  in_be = '0;
    logic             err_pulse;
    logic             err_sticky;
    logic [CNT_W-1:0] err_beat;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    be_burst_checker #(.BE_W(BE_W), .CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_burst   (in_burst),
        .in_be      (in_be),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky),
        .err_beat   (err_beat)
    );

    function automatic bit ok_first(input logic [3:0] v);
        case (v)
            4'b1111, 4'b1110, 4'b1100, 4'b1000: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit ok_last(input logic [3:0] v);
        case (v)
            4'b1111, 4'b0111, 4'b0011, 4'b0001: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit ok_single(input logic [3:0] v);
        case (v)
            4'b1111, 4'b0011, 4'b1100, 4'b0001,
            4'b0010, 4'b0100, 4'b1000: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one beat at a falling edge, then sample the pulse at the next falling edge
    task automatic beat(input int blen, input logic [3:0] be, input bit rdy,
                        input bit exp_err, input string req);
        in_valid = 1'b1;
        in_ready = rdy;
        in_burst = CNT_W'(blen);
        in_be    = be;
        @(negedge clk);
        in_valid = 1'b0;
        in_ready = 1'b0;
        check(err_pulse == exp_err, req, int'(err_pulse), int'(exp_err));
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(err_pulse == 1'b0, "R10 pulse", int'(err_pulse), 0);
        check(err_sticky == 1'b0, "R10 sticky", int'(err_sticky), 0);
        check(err_beat == '0, "R10 beat", int'(err_beat), 0);
    endtask

    task automatic t_single_sweep();
        for (int v = 0; v < 16; v++) beat(1, 4'(v), 1'b1, !ok_single(4'(v)), "R4 len1");
        beat(0, 4'b0101, 1'b1, 1'b1, "R4 len0 gap");
        beat(0, 4'b0010, 1'b1, 1'b0, "R4 len0 byte");
    endtask

    task automatic t_first_sweep();
        for (int v = 0; v < 16; v++) begin
            beat(2, 4'(v), 1'b1, !ok_first(4'(v)), "R1 open");
            beat(2, 4'b1111, 1'b1, 1'b0, "R1 close");
        end
    endtask

    task automatic t_last_sweep();
        for (int v = 0; v < 16; v++) begin
            beat(2, 4'b1111, 1'b1, 1'b0, "R2 open");
            beat(2, 4'(v), 1'b1, !ok_last(4'(v)), "R2 close");
        end
    endtask

    task automatic t_mid_sweep();
        for (int v = 0; v < 16; v++) begin
            beat(3, 4'b1111, 1'b1, 1'b0, "R3 open");
            beat(3, 4'(v), 1'b1, (v != 15), "R3 middle");
            beat(3, 4'b1111, 1'b1, 1'b0, "R3 close");
        end
    endtask

    task automatic t_stall();
        beat(3, 4'b1111, 1'b1, 1'b0, "R5 open");
        for (int i = 0; i < 3; i++) beat(3, 4'b0101, 1'b0, 1'b0, "R11 stall");
        // still a middle beat after the stall, so 0111 must be rejected
        beat(3, 4'b0111, 1'b1, 1'b1, "R5 middle after stall");
        beat(3, 4'b0001, 1'b1, 1'b0, "R5 close");
        // next beat opens a fresh burst
        beat(2, 4'b1000, 1'b1, 1'b0, "R5 new open");
        beat(2, 4'b0001, 1'b1, 1'b0, "R5 new close");
    endtask

    task automatic t_len_ignored();
        beat(4, 4'b1111, 1'b1, 1'b0, "R6 open");
        beat(1, 4'b0011, 1'b1, 1'b1, "R6 middle len1");
        beat(1, 4'b1111, 1'b1, 1'b0, "R6 middle full");
        beat(9, 4'b0011, 1'b1, 1'b0, "R6 close");
    endtask

    task automatic t_capture();
        t_reset();
        beat(4, 4'b1111, 1'b1, 1'b0, "R9 b0");
        beat(4, 4'b1111, 1'b1, 1'b0, "R9 b1");
        beat(4, 4'b0111, 1'b1, 1'b1, "R9 b2 bad");
        check(err_sticky == 1'b1, "R8 set", int'(err_sticky), 1);
        check(err_beat == 8'd2, "R9 index", int'(err_beat), 2);
        beat(4, 4'b1110, 1'b1, 1'b1, "R9 b3 bad");
        @(negedge clk);
        check(err_pulse == 1'b0, "R7 one cycle", int'(err_pulse), 0);
        check(err_beat == 8'd2, "R9 kept", int'(err_beat), 2);
        beat(1, 4'b1111, 1'b1, 1'b0, "R7 legal");
        repeat (3) @(negedge clk);
        check(err_sticky == 1'b1, "R8 held", int'(err_sticky), 1);
        t_reset();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_sweep();
        t_first_sweep();
        t_last_sweep();
        t_mid_sweep();
        t_stall();
        t_len_ignored();
        t_capture();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule